// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers twenty-two maskable interrupt sources from on-chip peripherals and external pins. It latches each rising source edge in a pending flag. It gates the pending requests with one global enable and a per-source enable. It then picks the single winning request using a fixed order in which the lower source number is served first.

The CPU core tells the block when it is in the final cycle of an instruction. At that point the block may accept the winner. One cycle later it presents a registered accept pulse together with the 16-bit vector address of the winner's service slot. The vector slots start at 0x0003 and are spaced 8 bytes apart. Reset uses address 0x0000 and is never routed through this block.

Acceptance clears the winner's pending flag and marks the controller as busy. No further request is accepted until the core pulses return-from-interrupt, so service routines never nest. A small register port lets software set the enables, read the flags and clear flags.

Source 19 has no flag. Its request follows the live input level.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A flag sets on a 0-to-1 transition of its source input, not on a steady high level. Flags read back at address 4+g, where bit b is source 6g+b.
- R2: A register write to a flag address clears each flag whose data bit is 0 and leaves flags whose data bit is 1. If a source edge and a software clear hit the same flag in the same cycle, the flag ends up set.
- R3: Address g (0 to 3), bit b (0 to 5) is the enable of source 6g+b, and it reads back as written. Bit 6 of address 0 is the global enable. Bits with no source behind them read as 0.
- R4: A request takes part in arbitration only while both the global enable and its own enable are 1.
- R5: When several requests are eligible, the lowest source number wins.
- R6: The vector for source n is 0x0003 + 8·n, which runs from 0x0003 for source 0 to 0x00AB for source 21.
- R7: A request is accepted only in a cycle where instr_last_i is 1. The accept pulse and the vector appear one cycle later for exactly one cycle. At all other times the vector output is 0.
- R8: The flag of the accepted source is 0 from the cycle the accept pulse is visible.
- R9: Source 19 has no flag and always reads 0. Its request is its live input level, taken while the input is high and absent once it falls.
- R10: After an accept, no other request is accepted until reti_i has been sampled high.
- R11: Reset clears every flag, every enable, the global enable, the busy state, the accept pulse and the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 22 | Source request lines, bit n is source n |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0-3 enables, 4-7 flags) |
| reg_wdata_i | input | 7 | Register write data |
| reg_rdata_o | output | 7 | Register read data for reg_addr_i |
| instr_last_i | input | 1 | Core is in the final cycle of an instruction |
| reti_i | input | 1 | Return-from-interrupt pulse from the core |
| irq_take_o | output | 1 | Registered accept pulse |
| irq_vector_o | output | 16 | Vector address, valid with irq_take_o, else 0 |

## Verification
The bench raises sources on the same cycle to confirm the lowest number wins. A reversed priority chain would jump to the wrong vector. It also lands a source edge and a write-zero clear on the same flag in one cycle; a design that lets the clear win would lose the request. It holds the flagless source high and then low. A design that latched it would keep requesting after the level dropped, or would show a flag bit. It keeps instr_last_i high during a service routine to catch a controller that nests without waiting for reti_i. It also clears the global enable while requests are pending, which a design that ignores the global enable would still accept. Long random runs of edges, writes, boundaries and returns are compared against a cycle model in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned SRC_COUNT   = 22;
  localparam int unsigned GROUP_BITS  = 6;
  localparam int unsigned GROUP_COUNT = (SRC_COUNT + GROUP_BITS - 1) / GROUP_BITS;
  localparam int unsigned REG_DW      = GROUP_BITS + 1;
  localparam int unsigned REG_AW      = 3;
  localparam int unsigned FLAG_ADDR0  = 4;
  localparam int unsigned LIVE_SRC    = 19;
  localparam int unsigned VEC_DW      = 16;
  localparam int unsigned VEC_FIRST   = 3;
  localparam int unsigned VEC_SPACING = 8;
  localparam int unsigned SEL_W       = $clog2(SRC_COUNT);

  typedef struct packed {
    logic             hit;
    logic [SEL_W-1:0] sel;
  } grant_t;
endpackage

// File: rtl/irqc_enable_regs.sv
module irqc_enable_regs #(
  parameter int unsigned N_SRC  = 22,
  parameter int unsigned GRP_W  = 6,
  parameter int unsigned AW     = 3,
  parameter int unsigned DW     = GRP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [N_SRC-1:0] src_en,
  output logic             glb_en
);
  logic [N_SRC-1:0] en_q, en_d;
  logic             glb_q, glb_d;

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_en
    localparam int unsigned GRP = gi / GRP_W;
    localparam int unsigned BIT = gi % GRP_W;
    logic hit;
    assign hit       = wr_en && (wr_addr == AW'(GRP));
    assign en_d[gi]  = hit ? wr_data[BIT] : en_q[gi];
  end

  always_comb begin
    glb_d = glb_q;
    if (wr_en && (wr_addr == '0)) glb_d = wr_data[GRP_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      glb_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      glb_q <= glb_d;
    end
  end

  assign src_en = en_q;
  assign glb_en = glb_q;
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned N_SRC     = 22,
  parameter int unsigned GRP_W     = 6,
  parameter int unsigned AW        = 3,
  parameter int unsigned FLAG_BASE = 4,
  parameter int unsigned NOFLAG    = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [GRP_W-1:0] wr_data,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] req_o
);
  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
    localparam int unsigned GRP = gi / GRP_W;
    localparam int unsigned BIT = gi % GRP_W;
    if (gi == NOFLAG) begin : g_live
      assign flag_o[gi] = 1'b0;
      assign req_o[gi]  = src_i[gi];
    end else begin : g_latched
      logic prev_q, flag_q, flag_d, edge_set, sw_clr;
      assign edge_set = src_i[gi] & ~prev_q;
      assign sw_clr   = wr_en && (wr_addr == AW'(FLAG_BASE + GRP)) && !wr_data[BIT];
      assign flag_d   = edge_set | (flag_q & ~sw_clr & ~ack_i[gi]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          flag_q <= 1'b0;
        end else begin
          prev_q <= src_i[gi];
          flag_q <= flag_d;
        end
      end

      assign flag_o[gi] = flag_q;
      assign req_o[gi]  = flag_q;
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 22,
  parameter int unsigned SW    = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             hit_o,
  output logic [SW-1:0]    sel_o
);
  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        sel_o = SW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = SRC_COUNT,
  parameter int unsigned GRP_W  = GROUP_BITS,
  parameter int unsigned AW     = REG_AW,
  parameter int unsigned VW     = VEC_DW,
  parameter int unsigned V0     = VEC_FIRST,
  parameter int unsigned VSTEP  = VEC_SPACING,
  parameter int unsigned NOFLAG = LIVE_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_src_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [GRP_W:0]   reg_wdata_i,
  output logic [GRP_W:0]   reg_rdata_o,
  input  logic             instr_last_i,
  input  logic             reti_i,
  output logic             irq_take_o,
  output logic [VW-1:0]    irq_vector_o
);
  localparam int unsigned N_GRP = (N_SRC + GRP_W - 1) / GRP_W;
  localparam int unsigned SW    = $clog2(N_SRC);
  localparam int unsigned FBASE = FLAG_ADDR0;

  logic [N_SRC-1:0] src_en, flags, pend, elig, ack_oh;
  logic             glb_en;
  grant_t           grant;
  logic             take_d, take_q;
  logic [VW-1:0]    vec_d, vec_q;
  logic             in_svc_d, in_svc_q;

  irqc_enable_regs #(.N_SRC(N_SRC), .GRP_W(GRP_W), .AW(AW), .DW(GRP_W + 1)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we_i), .wr_addr(reg_addr_i),
    .wr_data(reg_wdata_i), .src_en(src_en), .glb_en(glb_en)
  );

  irqc_pending #(.N_SRC(N_SRC), .GRP_W(GRP_W), .AW(AW), .FLAG_BASE(FBASE),
                 .NOFLAG(NOFLAG)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_i(irq_src_i), .wr_en(reg_we_i),
    .wr_addr(reg_addr_i), .wr_data(reg_wdata_i[GRP_W-1:0]), .ack_i(ack_oh),
    .flag_o(flags), .req_o(pend)
  );

  assign elig = pend & src_en & {N_SRC{glb_en}};

  irqc_prio #(.N_SRC(N_SRC), .SW(SW)) u_prio (
    .req_i(elig), .hit_o(grant.hit), .sel_o(grant.sel)
  );

  // Acceptance: instruction boundary, winner present, not already servicing
  always_comb begin
    take_d   = instr_last_i & grant.hit & ~in_svc_q;
    ack_oh   = take_d ? (N_SRC'(1) << grant.sel) : '0;
    vec_d    = take_d ? VW'(V0 + VSTEP * int'(grant.sel)) : '0;
    in_svc_d = take_d | (in_svc_q & ~reti_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q   <= 1'b0;
      vec_q    <= '0;
      in_svc_q <= 1'b0;
    end else begin
      take_q   <= take_d;
      vec_q    <= vec_d;
      in_svc_q <= in_svc_d;
    end
  end

  // Register readback: enables at 0..N_GRP-1, flags at FBASE..
  always_comb begin
    reg_rdata_o = '0;
    for (int g = 0; g < N_GRP; g++) begin
      for (int b = 0; b < GRP_W; b++) begin
        if (g * GRP_W + b < N_SRC) begin
          if (reg_addr_i == AW'(g))         reg_rdata_o[b] = src_en[g * GRP_W + b];
          if (reg_addr_i == AW'(FBASE + g)) reg_rdata_o[b] = flags[g * GRP_W + b];
        end
      end
    end
    if (reg_addr_i == '0) reg_rdata_o[GRP_W] = glb_en;
  end

  assign irq_take_o   = take_q;
  assign irq_vector_o = vec_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned VW     = 16,
  parameter int unsigned VLIMIT = 16'h00AB
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_last_i,
  input logic          reti_i,
  input logic          irq_take_o,
  input logic [VW-1:0] irq_vector_o,
  input logic          glb_en,
  input logic          in_svc_q
);
  assert_take_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |=> !irq_take_o);

  assert_take_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> $past(instr_last_i));

  assert_vector_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take_o |-> (irq_vector_o == '0));

  assert_vector_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take_o |-> (irq_vector_o[2:0] == 3'd3 && irq_vector_o <= VW'(VLIMIT)));

  assert_global_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(glb_en) |-> !irq_take_o);

  assert_no_nesting_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_svc_q) |-> !irq_take_o);

  assert_busy_until_reti_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_q && !reti_i) |=> in_svc_q);
endmodule

bind irq_vector_ctrl irqc_checker #(.VW(VW), .VLIMIT(V0 + VSTEP * (N_SRC - 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_last_i(instr_last_i), .reti_i(reti_i),
  .irq_take_o(irq_take_o), .irq_vector_o(irq_vector_o), .glb_en(glb_en),
  .in_svc_q(in_svc_q)
);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  localparam int NS = 22;
  localparam int LIVE = 19;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src;
  logic          we, instr, reti;
  logic [2:0]    addr;
  logic [6:0]    wdata, rdata;
  logic          take;
  logic [15:0]   vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src_i(src), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .instr_last_i(instr), .reti_i(reti),
    .irq_take_o(take), .irq_vector_o(vec)
  );

  always #5 clk = ~clk;

  // Cycle model built from the requirements
  logic [NS-1:0] m_flag, m_prev, m_en, nf;
  logic          m_ge, m_svc, m_take, tk, r;
  logic [15:0]   m_vec;
  int            win;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = '0; m_prev = '0; m_en = '0; m_ge = 0; m_svc = 0; m_take = 0; m_vec = '0;
    end else begin
      win = -1;
      for (int i = 0; i < NS; i++) begin
        r = (i == LIVE) ? src[i] : m_flag[i];
        if (r && m_en[i] && m_ge && win < 0) win = i;
      end
      tk = instr && (win >= 0) && !m_svc;
      for (int i = 0; i < NS; i++) begin
        if (i == LIVE) nf[i] = 1'b0;
        else nf[i] = (src[i] & ~m_prev[i]) |
                     (m_flag[i] & ~(we && addr == 3'(4 + i / 6) && !wdata[i % 6])
                                & ~(tk && win == i));
      end
      if (we && addr < 4)
        for (int i = 0; i < NS; i++) if (i / 6 == int'(addr)) m_en[i] = wdata[i % 6];
      if (we && addr == 0) m_ge = wdata[6];
      m_svc  = tk ? 1'b1 : (reti ? 1'b0 : m_svc);
      m_take = tk;
      m_vec  = tk ? 16'(3 + 8 * win) : 16'h0;
      m_flag = nf;
      m_prev = src;
    end
  end

  function automatic logic [6:0] m_read(input logic [2:0] a);
    logic [6:0] v = '0;
    for (int b = 0; b < 6; b++) begin
      int idx = (int'(a) % 4) * 6 + b;
      if (idx < NS) v[b] = (a < 4) ? m_en[idx] : m_flag[idx];
    end
    if (a == 0) v[6] = m_ge;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R7 take", 32'(take), 32'(m_take));
    chk("R6 vector", 32'(vec), 32'(m_vec));
    chk(addr < 4 ? "R3 enable readback" : "R1 flag readback", 32'(rdata), 32'(m_read(addr)));
  endtask

  task automatic wr(input logic [2:0] a, input logic [6:0] d);
    we = 1; addr = a; wdata = d; tick(); we = 0;
  endtask

  task automatic peek(input logic [2:0] a, input logic [6:0] exp, input string tag);
    addr = a; #1; chk(tag, 32'(rdata), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; src = '0; we = 0; instr = 0; reti = 0; addr = 0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 take", 32'(take), 0);
    chk("R11 vector", 32'(vec), 0);
    for (int a = 0; a < 8; a++) peek(3'(a), 7'h00, "R11 register");

    wr(0, 7'h7F); wr(1, 7'h3F); wr(2, 7'h3F); wr(3, 7'h3F);
    peek(3, 7'h0F, "R3 padded group");
    peek(0, 7'h7F, "R3 global bit");

    // R1 / R5 / R6 / R8 / R10
    src[2] = 1; src[4] = 1; tick();
    peek(4, 7'h14, "R1 edge sets flags");
    instr = 1; tick(); instr = 0;
    chk("R5 lowest wins take", 32'(take), 1);
    chk("R5 R6 vector src2", 32'(vec), 32'h13);
    peek(4, 7'h10, "R8 accepted flag cleared");
    instr = 1; tick(); chk("R10 blocked", 32'(take), 0);
    tick(); chk("R10 still blocked", 32'(take), 0);
    instr = 0; reti = 1; tick(); reti = 0;
    instr = 1; tick(); instr = 0;
    chk("R10 after reti vector src4", 32'(vec), 32'h23);
    tick(); reti = 1; tick(); reti = 0;
    src = '0; tick();
    peek(4, 7'h00, "R1 level does not re-set");

    // R2 set beats clear
    src[0] = 1; wr(4, 7'h00);
    peek(4, 7'h01, "R2 set wins over clear");
    wr(4, 7'h3E);
    peek(4, 7'h00, "R2 write zero clears");

    // R4 global gate
    wr(0, 7'h3F);
    src[1] = 1; tick();
    instr = 1; tick(); chk("R4 global off no take", 32'(take), 0);
    tick(); instr = 0;
    wr(0, 7'h7F);
    instr = 1; tick(); instr = 0;
    chk("R4 re-enabled vector src1", 32'(vec), 32'h0B);
    tick(); reti = 1; tick(); reti = 0;

    // R4 individual disable
    src = '0; tick(); wr(0, 7'h5F);
    src[5] = 1; tick(); instr = 1; tick(); chk("R4 source disabled", 32'(take), 0);
    instr = 0; wr(0, 7'h7F); instr = 1; tick(); instr = 0;
    chk("R6 vector src5", 32'(vec), 32'h2B);
    tick(); reti = 1; tick(); reti = 0;

    // R9 flagless live source
    src = '0; tick();
    src[LIVE] = 1; tick();
    peek(7, 7'h00, "R9 no flag");
    instr = 1; tick(); instr = 0;
    chk("R9 live vector", 32'(vec), 32'h9B);
    src[LIVE] = 0; tick(); reti = 1; tick(); reti = 0;
    instr = 1; tick(); instr = 0;
    chk("R9 dropped level not taken", 32'(take), 0);

    // R6 top boundary
    src[21] = 1; tick(); instr = 1; tick(); instr = 0;
    chk("R6 vector src21", 32'(vec), 32'hAB);
    tick(); reti = 1; tick(); reti = 0; src = '0;

    // Random phase, fixed seed
    void'($urandom(32'h1F2E3D4C));
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < NS; i++) if ($urandom_range(0, 15) == 0) src[i] = ~src[i];
      instr = ($urandom_range(0, 2) == 0);
      reti  = m_svc && ($urandom_range(0, 3) == 0);
      we    = ($urandom_range(0, 11) == 0);
      addr  = 3'($urandom_range(0, 7));
      wdata = 7'($urandom);
      if (we && addr == 0) wdata[6] = ($urandom_range(0, 3) != 0);
      tick();
    end
    we = 0; instr = 0; reti = 0;

    // R11 reset mid-run
    src = '1; tick();
    rst_n = 0; #1;
    chk("R11 async take clear", 32'(take), 0);
    @(negedge clk); rst_n = 1; src = '0;
    for (int a = 0; a < 8; a++) peek(3'(a), 7'h00, "R11 register after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule